// File: doc/BRIEF.md
# Predicated Vector Element Issue Sequencer

This block expands one register-to-register ALU instruction, written in scalar form, into a series of scalar element operations that walk a span of the ordinary register file. An instruction carries a destination and two source register numbers, a flag for each of the three that marks it as vectorised, a global vector length and the vector length configured for the destination. For each element it issues, the block presents the three register numbers and a write enable to a downstream scalar ALU through a valid/ready handshake.

Predication is looked up in a small keyed table. Each entry names a register to be predicated and the integer register that holds its mask. An entry can also ask for the mask to be inverted. When an instruction is accepted, the block reads the mask register through a read port, latches the mask, and skips every element whose mask bit is clear. A skipped element issues nothing, so its destination keeps its old value. A vectorised operand moves to the next register at each element index, whether or not that element was skipped. A scalar operand stays on its base register.

Top module: `pei_issue_seq`

## Requirements
- R1: After reset, `start_ready_o` is 1 and `op_valid_o` and `done_o` are 0. All table entries are disabled, so `pred_raddr_o` reads 0.
- R2: The number of element indices walked is the smaller of `vl_i` and `rd_len_i`, and is further clamped to XLEN (32). The mask is one bit per element and lives in one XLEN-wide register.
- R3: Element i is issued only when bit i of the effective mask is 1. An element with a clear mask bit produces no handshake and no write enable.
- R4: For element index i, each operand's register number is its base plus i (modulo 32) when its vectorised flag is 1, and its base unchanged when the flag is 0.
- R5: A table entry is written as `{enable[12], fp_select[11], key[10:6], mask_reg[5:1], invert[0]}`. An entry matches when it is enabled, its fp_select equals `is_fp_i`, and its key equals `rd_i`. On a match, `pred_raddr_o` carries that entry's mask_reg.
- R6: When the matching entry has invert set, the register value is bitwise complemented before element bits are tested.
- R7: When no entry matches, every element is enabled and `pred_raddr_o` is 0.
- R8: When several entries match, the lowest-numbered entry decides. Disabling it hands control to the next matching entry.
- R9: While `op_valid_o` is 1 and `op_ready_i` is 0, the op outputs hold steady. `op_we_o` is 1 exactly in cycles where both `op_valid_o` and `op_ready_i` are 1, and each such cycle issues one element.
- R10: `done_o` pulses for one cycle after the last element index has been walked. If the walked count is zero, `done_o` pulses in the cycle after acceptance and no element is issued.
- R11: `start_ready_o` is 0 from the cycle after an instruction with a nonzero walked count is accepted until its `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we_i | input | 1 | Predicate table write strobe |
| tbl_idx_i | input | 2 | Entry number to write |
| tbl_wdata_i | input | 13 | Entry contents (layout in R5) |
| start_valid_i | input | 1 | Instruction offered |
| start_ready_o | output | 1 | Sequencer idle and able to accept |
| is_fp_i | input | 1 | Destination register file is floating point |
| rd_i | input | 5 | Destination base register |
| rs1_i | input | 5 | Source 1 base register |
| rs2_i | input | 5 | Source 2 base register |
| rd_vec_i | input | 1 | Destination is vectorised |
| rs1_vec_i | input | 1 | Source 1 is vectorised |
| rs2_vec_i | input | 1 | Source 2 is vectorised |
| vl_i | input | 6 | Global vector length |
| rd_len_i | input | 6 | Vector length configured for the destination |
| pred_raddr_o | output | 5 | Integer register read address for the mask |
| pred_rdata_i | input | 32 | Value of that register, same cycle |
| op_valid_o | output | 1 | Element operation offered |
| op_ready_i | input | 1 | ALU accepts the element |
| op_rd_o | output | 5 | Element destination register |
| op_rs1_o | output | 5 | Element source 1 register |
| op_rs2_o | output | 5 | Element source 2 register |
| op_we_o | output | 1 | Element write enable (handshake cycle) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after masks with gaps and an inverted mask. A design that zeroed or issued masked elements would produce extra scoreboard items, and one that ignored inversion would issue the wrong indices. It mixes scalar and vectorised operands and uses a base near 31 so register numbers wrap. A design that stepped scalar operands, or carried into a sixth bit, would show wrong register numbers. Duplicate keys, a floating-point selector mismatch, a zero length, a length over 32 and a stalling ALU cover the remaining cases. Wrong priority, a missing clamp, a hung zero-length instruction or ops that change while stalled would each show up as a mismatch.

// File: rtl/pei_pkg.sv
package pei_pkg;

    localparam int unsigned REG_AW = 5;

    typedef struct packed {
        logic              en;
        logic              fp;
        logic [REG_AW-1:0] key;
        logic [REG_AW-1:0] preg;
        logic              inv;
    } pred_ent_t;

    localparam int unsigned ENT_W = $bits(pred_ent_t);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;

endpackage

// File: rtl/pei_pred_table.sv
module pei_pred_table
    import pei_pkg::*;
#(
    parameter int unsigned N_ENT = 4,
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  pred_ent_t         wr_ent_i,
    input  logic              look_fp_i,
    input  logic [REG_AW-1:0] look_key_i,
    output logic              hit_o,
    output logic [REG_AW-1:0] preg_o,
    output logic              inv_o
);

    typedef struct packed {
        pred_ent_t [N_ENT-1:0] ent;
    } tbl_s;

    tbl_s s_d, s_q;
    logic [N_ENT-1:0] match;

    always_comb begin
        s_d = s_q;
        if (wr_en_i) begin
            s_d.ent[wr_idx_i] = wr_ent_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_match
            assign match[g] = s_q.ent[g].en
                           && (s_q.ent[g].fp == look_fp_i)
                           && (s_q.ent[g].key == look_key_i);
        end
    endgenerate

    // Scan from the top down so the lowest-numbered match is the last one written.
    always_comb begin
        hit_o  = 1'b0;
        preg_o = '0;
        inv_o  = 1'b0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o  = 1'b1;
                preg_o = s_q.ent[i].preg;
                inv_o  = s_q.ent[i].inv;
            end
        end
    end

    // R5: a written entry is held in the table on the following cycle
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (s_q.ent[$past(wr_idx_i)] == $past(wr_ent_i)));

    // R7: a miss leaves the mask address at zero
    a_r7_miss_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (match == '0) |-> (!hit_o && preg_o == '0 && !inv_o));

endmodule

// File: rtl/pei_elem_walker.sv
module pei_elem_walker #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned LEN_W = $clog2(XLEN + 1),
    localparam int unsigned BIT_W = $clog2(XLEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] vl_i,
    input  logic [LEN_W-1:0] dlen_i,
    input  logic [XLEN-1:0]  mask_i,
    input  logic             step_i,
    output logic [LEN_W-1:0] idx_o,
    output logic             end_o,
    output logic             bit_o,
    output logic             zero_o
);

    typedef struct packed {
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] lim;
        logic [XLEN-1:0]  mask;
    } walk_s;

    walk_s s_d, s_q;
    logic [LEN_W-1:0] lim_new;

    always_comb begin
        lim_new = (vl_i < dlen_i) ? vl_i : dlen_i;
        if (lim_new > LEN_W'(XLEN)) begin
            lim_new = LEN_W'(XLEN);
        end
    end

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.idx  = '0;
            s_d.lim  = lim_new;
            s_d.mask = mask_i;
        end else if (step_i) begin
            s_d.idx = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idx_o  = s_q.idx;
    assign end_o  = (s_q.idx == s_q.lim);
    assign bit_o  = s_q.mask[s_q.idx[BIT_W-1:0]];
    assign zero_o = (lim_new == '0);

    // R2: the element index never runs past the walked count
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idx <= s_q.lim);

    // R2: the walked count never exceeds the mask width
    a_r2_lim_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lim <= LEN_W'(XLEN));

    // R10: no advance is requested once the walk has ended
    a_r10_no_step_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |-> !end_o);

endmodule

// File: rtl/pei_issue_seq.sv
module pei_issue_seq
    import pei_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned N_ENT = 4,
    localparam int unsigned LEN_W = $clog2(XLEN + 1),
    localparam int unsigned TIX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we_i,
    input  logic [TIX_W-1:0]  tbl_idx_i,
    input  logic [ENT_W-1:0]  tbl_wdata_i,
    input  logic              start_valid_i,
    output logic              start_ready_o,
    input  logic              is_fp_i,
    input  logic [REG_AW-1:0] rd_i,
    input  logic [REG_AW-1:0] rs1_i,
    input  logic [REG_AW-1:0] rs2_i,
    input  logic              rd_vec_i,
    input  logic              rs1_vec_i,
    input  logic              rs2_vec_i,
    input  logic [LEN_W-1:0]  vl_i,
    input  logic [LEN_W-1:0]  rd_len_i,
    output logic [REG_AW-1:0] pred_raddr_o,
    input  logic [XLEN-1:0]   pred_rdata_i,
    output logic              op_valid_o,
    input  logic              op_ready_i,
    output logic [REG_AW-1:0] op_rd_o,
    output logic [REG_AW-1:0] op_rs1_o,
    output logic [REG_AW-1:0] op_rs2_o,
    output logic              op_we_o,
    output logic              done_o
);

    typedef struct packed {
        seq_st_e           st;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rs1;
        logic [REG_AW-1:0] rs2;
        logic              rd_v;
        logic              rs1_v;
        logic              rs2_v;
        logic              done;
    } seq_s;

    seq_s s_d, s_q;

    logic              hit;
    logic              inv;
    logic [REG_AW-1:0] preg;
    logic [XLEN-1:0]   mask_eff;
    logic              load;
    logic              step;
    logic [LEN_W-1:0]  idx;
    logic              at_end;
    logic              cur_bit;
    logic              len_zero;
    logic [REG_AW-1:0] off;
    logic              issue;

    pei_pred_table #(.N_ENT(N_ENT)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (tbl_we_i),
        .wr_idx_i   (tbl_idx_i),
        .wr_ent_i   (pred_ent_t'(tbl_wdata_i)),
        .look_fp_i  (is_fp_i),
        .look_key_i (rd_i),
        .hit_o      (hit),
        .preg_o     (preg),
        .inv_o      (inv)
    );

    assign pred_raddr_o = preg;
    assign mask_eff     = !hit ? '1 : (inv ? ~pred_rdata_i : pred_rdata_i);

    pei_elem_walker #(.XLEN(XLEN)) u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .vl_i   (vl_i),
        .dlen_i (rd_len_i),
        .mask_i (mask_eff),
        .step_i (step),
        .idx_o  (idx),
        .end_o  (at_end),
        .bit_o  (cur_bit),
        .zero_o (len_zero)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        issue    = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_valid_i) begin
                    load      = 1'b1;
                    s_d.rd    = rd_i;
                    s_d.rs1   = rs1_i;
                    s_d.rs2   = rs2_i;
                    s_d.rd_v  = rd_vec_i;
                    s_d.rs1_v = rs1_vec_i;
                    s_d.rs2_v = rs2_vec_i;
                    if (len_zero) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (at_end) begin
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end else if (!cur_bit) begin
                    step = 1'b1;
                end else begin
                    issue = 1'b1;
                    step  = op_ready_i;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign off           = REG_AW'(idx);
    assign start_ready_o = (s_q.st == ST_IDLE);
    assign op_valid_o    = issue;
    assign op_rd_o       = s_q.rd  + (s_q.rd_v  ? off : '0);
    assign op_rs1_o      = s_q.rs1 + (s_q.rs1_v ? off : '0);
    assign op_rs2_o      = s_q.rs2 + (s_q.rs2_v ? off : '0);
    assign op_we_o       = issue && op_ready_i;
    assign done_o        = s_q.done;

    // R9: a stalled element stays offered with unchanged register numbers
    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_o && !op_ready_i) |=>
            (op_valid_o && $stable(op_rd_o) && $stable(op_rs1_o) && $stable(op_rs2_o)));

    // R9: write enable only accompanies an offered element
    a_r9_we_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        op_we_o |-> op_valid_o);

    // R11: no new instruction is accepted while elements are being offered
    a_r11_busy_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_o |-> !start_ready_o);

    // R10: the completion pulse is a single cycle and never overlaps an issue
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !op_valid_o);

endmodule

// File: tb/tb_pei_issue_seq.sv
module tb_pei_issue_seq;

    localparam int XLEN = 32;
    localparam int LW   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_idx = '0;
    logic [12:0] tbl_wdata = '0;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic        is_fp = 1'b0;
    logic [4:0]  rd = '0, rs1 = '0, rs2 = '0;
    logic        rd_v = 1'b0, rs1_v = 1'b0, rs2_v = 1'b0;
    logic [LW-1:0] vl = '0, rd_len = '0;
    logic [4:0]  pred_raddr;
    logic [31:0] pred_rdata;
    logic        op_valid;
    logic        op_ready = 1'b1;
    logic [4:0]  op_rd, op_rs1, op_rs2;
    logic        op_we;
    logic        done;

    logic [31:0] rf [32];
    logic [12:0] shadow [4];
    logic [14:0] expq [$];

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    int rdy_cnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign pred_rdata = rf[pred_raddr];

    pei_issue_seq dut (
        .clk(clk), .rst_n(rst_n),
        .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_wdata_i(tbl_wdata),
        .start_valid_i(start_valid), .start_ready_o(start_ready),
        .is_fp_i(is_fp), .rd_i(rd), .rs1_i(rs1), .rs2_i(rs2),
        .rd_vec_i(rd_v), .rs1_vec_i(rs1_v), .rs2_vec_i(rs2_v),
        .vl_i(vl), .rd_len_i(rd_len),
        .pred_raddr_o(pred_raddr), .pred_rdata_i(pred_rdata),
        .op_valid_o(op_valid), .op_ready_i(op_ready),
        .op_rd_o(op_rd), .op_rs1_o(op_rs1), .op_rs2_o(op_rs2),
        .op_we_o(op_we), .done_o(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ALU ready pattern, changed just after the rising edge
    always @(posedge clk) begin
        #2;
        rdy_cnt++;
        if (rdy_mode == 0) op_ready = 1'b1;
        else op_ready = ((rdy_cnt % 3) != 0);
    end

    // Monitor: pops the scoreboard on each handshake, checks stall stability
    logic        prev_stall = 1'b0;
    logic [14:0] prev_ops = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(op_valid && {op_rd, op_rs1, op_rs2} == prev_ops, "R9",
                    "stalled op changed", {op_valid, op_rd, op_rs1, op_rs2}, {1'b1, prev_ops});
            end
            if (op_valid) begin
                chk(start_ready == 1'b0, "R11", "ready while busy", start_ready, 0);
            end
            chk(op_we == (op_valid && op_ready), "R9", "write enable",
                op_we, op_valid && op_ready);
            if (op_valid && op_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R3", "unexpected element", {op_rd, op_rs1, op_rs2}, 0);
                end else begin
                    logic [14:0] e;
                    e = expq.pop_front();
                    chk({op_rd, op_rs1, op_rs2} == e, "R4", "element registers",
                        {op_rd, op_rs1, op_rs2}, e);
                end
            end
            prev_stall = op_valid && !op_ready;
            prev_ops   = {op_rd, op_rs1, op_rs2};
        end
    end

    task automatic tbl_write(input int idx, input bit en, input bit fp,
                             input int key, input int preg, input bit inv);
        @(negedge clk);
        tbl_we    = 1'b1;
        tbl_idx   = 2'(idx);
        tbl_wdata = {en, fp, 5'(key), 5'(preg), inv};
        shadow[idx] = tbl_wdata;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Driver: computes the expected element list, queues it, then offers the op
    task automatic run_op(input string tag, input bit fp, input int d, input int s1,
                          input int s2, input bit vd, input bit v1, input bit v2,
                          input int vlen, input int dlen);
        bit          hit = 1'b0;
        int          pr = 0;
        bit          iv = 1'b0;
        logic [31:0] m;
        int          lim;
        int          n;
        for (int k = 3; k >= 0; k--) begin
            if (shadow[k][12] && shadow[k][11] == fp && shadow[k][10:6] == 5'(d)) begin
                hit = 1'b1;
                pr  = int'(shadow[k][5:1]);
                iv  = shadow[k][0];
            end
        end
        m = !hit ? 32'hFFFF_FFFF : (iv ? ~rf[pr] : rf[pr]);
        lim = (vlen < dlen) ? vlen : dlen;
        if (lim > XLEN) lim = XLEN;
        for (int i = 0; i < lim; i++) begin
            if (m[i]) begin
                expq.push_back({5'(d + (vd ? i : 0)), 5'(s1 + (v1 ? i : 0)), 5'(s2 + (v2 ? i : 0))});
            end
        end
        @(negedge clk);
        is_fp = fp; rd = 5'(d); rs1 = 5'(s1); rs2 = 5'(s2);
        rd_v = vd; rs1_v = v1; rs2_v = v2;
        vl = LW'(vlen); rd_len = LW'(dlen);
        start_valid = 1'b1;
        #1;
        chk(start_ready == 1'b1, tag, "start_ready when idle", start_ready, 1);
        chk(pred_raddr == 5'(pr), tag, "mask register address", pred_raddr, pr);
        @(negedge clk);
        start_valid = 1'b0;
        n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R10", "done seen", done, 1);
        if (lim == 0) chk(n == 0, "R10", "zero-length done delay", n, 0);
        chk(expq.size() == 0, tag, "elements left at done", expq.size(), 0);
        expq.delete();
        @(negedge clk);
        chk(done == 1'b0, "R10", "done is one cycle", done, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = 32'(i * 32'h0101_0101);
        for (int i = 0; i < 4; i++) shadow[i] = '0;
        rf[9]  = 32'h0000_00B2;
        rf[10] = 32'h0000_000F;
        rf[11] = 32'h0000_0005;
        #20;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(start_ready == 1'b1, "R1", "start_ready after reset", start_ready, 1);
        chk(op_valid == 1'b0, "R1", "op_valid after reset", op_valid, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(pred_raddr == 5'd0, "R1", "empty table address", pred_raddr, 0);

        // R7 / R4: no predication, all vectorised
        run_op("R7", 1'b0, 4, 8, 12, 1, 1, 1, 5, 8);
        // R2: destination length smaller than VL
        run_op("R2", 1'b0, 4, 8, 12, 1, 1, 1, 10, 3);
        // R4: scalar source 1, scalar destination
        run_op("R4", 1'b0, 2, 3, 16, 1, 0, 1, 4, 4);
        run_op("R4", 1'b0, 7, 20, 21, 0, 1, 1, 3, 3);
        // R4: register number wraps past 31
        run_op("R4", 1'b0, 30, 29, 1, 1, 1, 0, 4, 6);

        // R5 / R3: keyed mask with gaps (bits 1,4,5,7)
        tbl_write(0, 1'b1, 1'b0, 4, 9, 1'b0);
        run_op("R3", 1'b0, 4, 8, 12, 1, 1, 1, 8, 8);
        // R6: inverted mask, only bits 4 and 5 survive within 6
        tbl_write(1, 1'b1, 1'b0, 6, 10, 1'b1);
        run_op("R6", 1'b0, 6, 0, 1, 1, 0, 1, 6, 6);
        // R5: selector mismatch means no match
        run_op("R5", 1'b1, 4, 8, 12, 1, 1, 1, 4, 4);
        // R8: duplicate key, lowest entry wins, then the next one takes over
        tbl_write(3, 1'b1, 1'b0, 4, 11, 1'b0);
        run_op("R8", 1'b0, 4, 8, 12, 1, 1, 1, 6, 6);
        tbl_write(0, 1'b0, 1'b0, 4, 9, 1'b0);
        run_op("R8", 1'b0, 4, 8, 12, 1, 1, 1, 6, 6);

        // R10: zero length completes at once
        run_op("R10", 1'b0, 5, 5, 5, 1, 1, 1, 0, 7);
        run_op("R10", 1'b0, 5, 5, 5, 1, 1, 1, 9, 0);
        // R2: length above 32 clamps to 32
        run_op("R2", 1'b0, 0, 1, 2, 1, 1, 1, 40, 63);

        // R9 / R11: stalling ALU
        rdy_mode = 1;
        run_op("R9", 1'b0, 10, 11, 12, 1, 1, 1, 12, 12);
        run_op("R11", 1'b0, 4, 3, 2, 1, 0, 1, 6, 6);
        rdy_mode = 0;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule